// File: doc/BRIEF.md
# Hoisted-Load Conflict Tracker

This block keeps a small fully associative record of loads that a scheduler has moved above stores that might alias them. Each record pairs a destination register number with the byte range the early load read. When a later store writes any byte of that range, the record is dropped. A check, keyed by register number, then tells the core whether the early value can be kept. A miss asks for a reload or a branch to recovery code, depending on the kind of check.

An advanced-load port writes records, a store port kills overlapping ones, and a check port looks a register up and can drop its record as it does so. A single input empties the whole table. A speculative load that has deferred a fault writes no record, so its later check fails. When all slots are in use, a round-robin pointer picks the record to overwrite. Losing a record this way only causes an extra reload.

Top module: `spec_load_table`

## Requirements
- R1: An advanced load (`alloc_valid`=1, `alloc_deferred`=0) records its register, and a check of that register in any later cycle hits until something removes the record.
- R2: A store (`st_valid`=1) removes every valid record whose byte range shares at least one byte with the store's byte range. Records whose ranges do not share a byte are kept.
- R3: A size code s on `alloc_size` or `st_size` covers 2^s bytes starting at the given address (0 is 1 byte, 1 is 2, 2 is 4, 3 is 8), and overlap is judged on these byte ranges.
- R4: One cycle after a check, `chk_done` is 1 and exactly one of `chk_hit`, `chk_reload`, `chk_redirect` is 1. A miss raises `chk_redirect` when `chk_branch`=1 and `chk_reload` when `chk_branch`=0. When no check was made, all four outputs are 0.
- R5: A check with `chk_clear`=1 removes the record of the checked register after the lookup, whether it hit or missed. Records of other registers are kept.
- R6: An advanced load with `alloc_deferred`=1 writes no record and removes any existing record of its register, so the next check of that register misses.
- R7: A new advanced load to a register that already has a record replaces that record. The old address range no longer counts.
- R8: Free slots fill from the lowest index upward. With all slots in use, an advanced load to a new register overwrites the slot named by a pointer that starts at 0 after reset and then steps by one for each such overwrite.
- R9: `inv_all`=1 removes every record in one cycle.
- R10: Store kills, clear-check kills and `inv_all` act only on records already present. An advanced load in the same cycle is written after them, and its record survives.
- R11: A check looks at the table as it stood before the cycle's own updates. An advanced load and a check of the same register in the same cycle give a miss, and a killing store in the same cycle still gives a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, empties the table and zeroes the pointer |
| alloc_valid | input | 1 | Advanced load presented this cycle |
| alloc_reg | input | REG_W | Destination register number of the advanced load |
| alloc_addr | input | ADDR_W | Start byte address of the advanced load |
| alloc_size | input | 2 | Size code of the advanced load (2^code bytes) |
| alloc_deferred | input | 1 | The load deferred a fault; no record is written |
| st_valid | input | 1 | Store presented this cycle |
| st_addr | input | ADDR_W | Start byte address of the store |
| st_size | input | 2 | Size code of the store (2^code bytes) |
| chk_valid | input | 1 | Check presented this cycle |
| chk_reg | input | REG_W | Register number to look up |
| chk_branch | input | 1 | 1: branching check, 0: reloading check |
| chk_clear | input | 1 | Drop the record after the lookup |
| inv_all | input | 1 | Empty the whole table |
| chk_done | output | 1 | A check result is presented |
| chk_hit | output | 1 | The record was present |
| chk_reload | output | 1 | Miss on a reloading check |
| chk_redirect | output | 1 | Miss on a branching check |

## Verification
The assertions assume that at most one valid record per register exists, which the design itself maintains. They also assume that a store and an advanced load in the same cycle are judged apart: the store-kill property only applies in cycles with no allocation, because an allocation may legally rewrite a slot the store has just killed. The stimulus drives every input between clock edges and returns all strobes to idle after each cycle. It exercises same-cycle combinations on purpose, but only in the pairings the requirements define. The overlap sweep covers every pair of sizes over store offsets from ten bytes below to ten bytes above a load, so every boundary touch and every near miss is hit.

// File: rtl/slt_pkg.sv
package slt_pkg;

  // size code to byte count: 2^code
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'(4'd1 << code);
  endfunction

  // half-open byte ranges [a, a+len_a) and [b, b+len_b) share a byte
  function automatic logic span_overlap(input logic [63:0] a, input logic [1:0] sa,
                                        input logic [63:0] b, input logic [1:0] sb);
    logic [64:0] a_end;
    logic [64:0] b_end;
    a_end = {1'b0, a} + 65'(size_bytes(sa));
    b_end = {1'b0, b} + 65'(size_bytes(sb));
    return ({1'b0, a} < b_end) && ({1'b0, b} < a_end);
  endfunction

endpackage

// File: rtl/slt_entry.sv
module slt_entry
  import slt_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              kill_ext,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic [REG_W-1:0]  alloc_reg,
  output logic              valid_o,
  output logic              st_kill_o,
  output logic              chk_match_o,
  output logic              alloc_match_o
);

  logic              valid_q;
  logic [REG_W-1:0]  reg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;

  // this record's range overlaps the store range
  assign st_kill_o     = valid_q && st_valid &&
                         span_overlap(64'(addr_q), size_q, 64'(st_addr), st_size);
  assign chk_match_o   = valid_q && (reg_q == chk_reg);
  assign alloc_match_o = valid_q && (reg_q == alloc_reg);
  assign valid_o       = valid_q;

  // writes are applied after every kind of kill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      reg_q   <= '0;
      addr_q  <= '0;
      size_q  <= '0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      reg_q   <= wr_reg;
      addr_q  <= wr_addr;
      size_q  <= wr_size;
    end else if (inv_all || st_kill_o || kill_ext) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/slt_victim.sv
module slt_victim #(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_fire,
  input  logic [ENTRIES-1:0] match_vec,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] wr_vec,
  output logic               evict
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] free_sel;
  logic               any_free;
  logic               any_match;
  logic [ENTRIES-1:0] rr_sel;

  // lowest free slot
  always_comb begin
    free_sel = '0;
    any_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_vec[i] && !any_free) begin
        free_sel[i] = 1'b1;
        any_free    = 1'b1;
      end
    end
  end

  always_comb begin
    rr_sel        = '0;
    rr_sel[ptr_q] = 1'b1;
  end

  assign any_match = |match_vec;
  assign evict     = alloc_fire && !any_match && !any_free;

  always_comb begin
    if (!alloc_fire)    wr_vec = '0;
    else if (any_match) wr_vec = match_vec;
    else if (any_free)  wr_vec = free_sel;
    else                wr_vec = rr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (evict) begin
      if (ptr_q == PTR_W'(ENTRIES - 1)) ptr_q <= '0;
      else                              ptr_q <= ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/slt_check_out.sv
module slt_check_out (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_valid,
  input  logic chk_branch,
  input  logic hit_any,
  output logic chk_done,
  output logic chk_hit,
  output logic chk_reload,
  output logic chk_redirect
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_done     <= 1'b0;
      chk_hit      <= 1'b0;
      chk_reload   <= 1'b0;
      chk_redirect <= 1'b0;
    end else begin
      chk_done     <= chk_valid;
      chk_hit      <= chk_valid && hit_any;
      chk_reload   <= chk_valid && !hit_any && !chk_branch;
      chk_redirect <= chk_valid && !hit_any && chk_branch;
    end
  end

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [1:0]        alloc_size,
  input  logic              alloc_deferred,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_branch,
  input  logic              chk_clear,
  input  logic              inv_all,
  output logic              chk_done,
  output logic              chk_hit,
  output logic              chk_reload,
  output logic              chk_redirect
);

  // named internal events, also observed by the bound checker
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] st_kill_vec;
  logic [ENTRIES-1:0] chk_match_vec;
  logic [ENTRIES-1:0] alloc_match_vec;
  logic [ENTRIES-1:0] wr_vec;
  logic [ENTRIES-1:0] kill_ext_vec;
  logic               alloc_fire;
  logic               alloc_drop;
  logic               clear_fire;
  logic               evict;
  logic               hit_any;

  assign alloc_fire = alloc_valid && !alloc_deferred;
  assign alloc_drop = alloc_valid && alloc_deferred;
  assign clear_fire = chk_valid && chk_clear;
  assign hit_any    = |chk_match_vec;

  assign kill_ext_vec = (clear_fire ? chk_match_vec   : '0) |
                        (alloc_drop ? alloc_match_vec : '0);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    slt_entry #(
      .REG_W  (REG_W),
      .ADDR_W (ADDR_W)
    ) u_entry (
      .clk           (clk),
      .rst_n         (rst_n),
      .inv_all       (inv_all),
      .kill_ext      (kill_ext_vec[g]),
      .wr_en         (wr_vec[g]),
      .wr_reg        (alloc_reg),
      .wr_addr       (alloc_addr),
      .wr_size       (alloc_size),
      .st_valid      (st_valid),
      .st_addr       (st_addr),
      .st_size       (st_size),
      .chk_reg       (chk_reg),
      .alloc_reg     (alloc_reg),
      .valid_o       (valid_vec[g]),
      .st_kill_o     (st_kill_vec[g]),
      .chk_match_o   (chk_match_vec[g]),
      .alloc_match_o (alloc_match_vec[g])
    );
  end

  slt_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .match_vec  (alloc_match_vec),
    .valid_vec  (valid_vec),
    .wr_vec     (wr_vec),
    .evict      (evict)
  );

  slt_check_out u_check_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_valid    (chk_valid),
    .chk_branch   (chk_branch),
    .hit_any      (hit_any),
    .chk_done     (chk_done),
    .chk_hit      (chk_hit),
    .chk_reload   (chk_reload),
    .chk_redirect (chk_redirect)
  );

endmodule

// File: rtl/slt_checker.sv
module slt_checker #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alloc_valid,
  input logic               alloc_deferred,
  input logic [REG_W-1:0]   alloc_reg,
  input logic               st_valid,
  input logic               chk_valid,
  input logic               chk_clear,
  input logic [REG_W-1:0]   chk_reg,
  input logic               inv_all,
  input logic               chk_done,
  input logic               chk_hit,
  input logic               chk_reload,
  input logic               chk_redirect,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] st_kill_vec,
  input logic [ENTRIES-1:0] chk_match_vec,
  input logic               evict
);

  p_alloc_then_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_deferred) ##1 (chk_valid && chk_reg == $past(alloc_reg))
    |=> chk_hit);

  p_store_kills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !alloc_valid) |=> ((valid_vec & $past(st_kill_vec)) == '0));

  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> $countones({chk_hit, chk_reload, chk_redirect}) == 1);

  p_quiet_without_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_done && !chk_hit && !chk_reload && !chk_redirect);

  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_clear && !alloc_valid) |=> ((valid_vec & $past(chk_match_vec)) == '0));

  p_deferred_misses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_deferred) ##1 (chk_valid && chk_reg == $past(alloc_reg))
    |=> !chk_hit);

  p_evict_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> (&valid_vec));

  p_grow_by_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(valid_vec) <= $countones($past(valid_vec)) + 1);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !alloc_valid) |=> (valid_vec == '0));

endmodule

bind spec_load_table slt_checker #(
  .ENTRIES (ENTRIES),
  .REG_W   (REG_W)
) u_slt_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .alloc_valid    (alloc_valid),
  .alloc_deferred (alloc_deferred),
  .alloc_reg      (alloc_reg),
  .st_valid       (st_valid),
  .chk_valid      (chk_valid),
  .chk_clear      (chk_clear),
  .chk_reg        (chk_reg),
  .inv_all        (inv_all),
  .chk_done       (chk_done),
  .chk_hit        (chk_hit),
  .chk_reload     (chk_reload),
  .chk_redirect   (chk_redirect),
  .valid_vec      (valid_vec),
  .st_kill_vec    (st_kill_vec),
  .chk_match_vec  (chk_match_vec),
  .evict          (evict)
);

// File: tb/spec_load_table_test.sv
module spec_load_table_test;

  localparam int ENTRIES = 16;
  localparam int REG_W   = 7;
  localparam int ADDR_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_valid = 1'b0;
  logic [REG_W-1:0]  alloc_reg = '0;
  logic [ADDR_W-1:0] alloc_addr = '0;
  logic [1:0]        alloc_size = '0;
  logic              alloc_deferred = 1'b0;
  logic              st_valid = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [1:0]        st_size = '0;
  logic              chk_valid = 1'b0;
  logic [REG_W-1:0]  chk_reg = '0;
  logic              chk_branch = 1'b0;
  logic              chk_clear = 1'b0;
  logic              inv_all = 1'b0;
  logic              chk_done, chk_hit, chk_reload, chk_redirect;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  spec_load_table #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr),
    .alloc_size(alloc_size), .alloc_deferred(alloc_deferred),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_branch(chk_branch), .chk_clear(chk_clear),
    .inv_all(inv_all),
    .chk_done(chk_done), .chk_hit(chk_hit), .chk_reload(chk_reload), .chk_redirect(chk_redirect)
  );

  // ---- stimulus helpers: set between edges, step, then idle ----
  task automatic set_alloc(input int r, input int a, input int s, input bit def);
    alloc_valid = 1'b1; alloc_reg = REG_W'(r); alloc_addr = ADDR_W'(a);
    alloc_size = 2'(s); alloc_deferred = def;
  endtask

  task automatic set_store(input int a, input int s);
    st_valid = 1'b1; st_addr = ADDR_W'(a); st_size = 2'(s);
  endtask

  task automatic set_chk(input int r, input bit br, input bit clr);
    chk_valid = 1'b1; chk_reg = REG_W'(r); chk_branch = br; chk_clear = clr;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 1'b0; alloc_deferred = 1'b0;
    st_valid = 1'b0; chk_valid = 1'b0; chk_clear = 1'b0; inv_all = 1'b0;
  endtask

  // compare check outputs sampled after the step that carried the check
  task automatic expect_chk(input bit exp_hit, input bit br, input string tag);
    logic [3:0] got, exp;
    got = {chk_done, chk_hit, chk_reload, chk_redirect};
    exp = {1'b1, exp_hit, !exp_hit && !br, !exp_hit && br};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: done/hit/reload/redirect got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_alloc(input int r, input int a, input int s);
    set_alloc(r, a, s, 1'b0); step();
  endtask

  task automatic do_chk(input int r, input bit br, input bit clr, input bit exp_hit,
                        input string tag);
    set_chk(r, br, clr); step(); expect_chk(exp_hit, br, tag);
  endtask

  task automatic do_flush();
    inv_all = 1'b1; step();
  endtask

  // byte-by-byte overlap, independent of the design's range compare
  function automatic bit bytes_touch(input int a, input int sa, input int b, input int sb);
    for (int i = 0; i < (1 << sa); i++)
      for (int j = 0; j < (1 << sb); j++)
        if (a + i == b + j) return 1'b1;
    return 1'b0;
  endfunction

  bit finished = 1'b0;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): run hung, got no end, expected end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state: no result presented (R4)
    n_cmp++;
    if ({chk_done, chk_hit, chk_reload, chk_redirect} !== 4'b0000) begin
      n_bad++;
      $display("FAIL R4 reset: outputs got %b expected 0000",
               {chk_done, chk_hit, chk_reload, chk_redirect});
    end
    do_chk(3, 1'b0, 1'b0, 1'b0, "R4 empty table reload miss");

    // R8: fill slots 0..15 with regs 0..15, then overwrite by pointer
    for (int k = 0; k < ENTRIES; k++) do_alloc(k, 'h100 + 16 * k, 3);
    for (int k = 0; k < ENTRIES; k++) do_chk(k, 1'b1, 1'b0, 1'b1, "R8 full table hit");
    do_alloc(16, 'h800, 3);
    do_chk(0, 1'b0, 1'b0, 1'b0, "R8 slot0 overwritten");
    do_chk(16, 1'b0, 1'b0, 1'b1, "R8 new record present");
    do_chk(1, 1'b0, 1'b0, 1'b1, "R8 slot1 kept");
    do_alloc(17, 'h900, 3);
    do_chk(1, 1'b1, 1'b0, 1'b0, "R8 pointer stepped to slot1");
    do_chk(2, 1'b1, 1'b0, 1'b1, "R8 slot2 kept");

    // R9: flush
    do_flush();
    do_chk(2, 1'b1, 1'b0, 1'b0, "R9 flush removed reg2");
    do_chk(16, 1'b0, 1'b0, 1'b0, "R9 flush removed reg16");

    // R1 basic allocate / hit
    do_alloc(10, 'h1000, 2);
    do_chk(10, 1'b0, 1'b0, 1'b1, "R1 hit after allocate");
    do_chk(10, 1'b1, 1'b0, 1'b1, "R1 still present");
    do_chk(11, 1'b1, 1'b0, 1'b0, "R4 other reg redirect miss");

    // R5 clear checks
    do_alloc(20, 'h1100, 3);
    do_chk(20, 1'b0, 1'b1, 1'b1, "R5 clear check hits");
    do_chk(20, 1'b0, 1'b0, 1'b0, "R5 record gone after clear");
    do_alloc(21, 'h1200, 3);
    do_chk(22, 1'b1, 1'b1, 1'b0, "R5 clear on missing reg misses");
    do_chk(21, 1'b1, 1'b0, 1'b1, "R5 other record kept");

    // R6 deferred loads
    set_alloc(30, 'h1300, 3, 1'b1); step();
    do_chk(30, 1'b1, 1'b0, 1'b0, "R6 deferred writes nothing");
    do_alloc(31, 'h1400, 3);
    set_alloc(31, 'h1400, 3, 1'b1); step();
    do_chk(31, 1'b0, 1'b0, 1'b0, "R6 deferred removes old record");

    // R7 replacement
    do_alloc(40, 'h2000, 3);
    do_alloc(40, 'h3000, 3);
    set_store('h2000, 0); step();
    do_chk(40, 1'b0, 1'b0, 1'b1, "R7 old range no longer kills");
    do_alloc(41, 'h2100, 3);
    do_alloc(41, 'h3100, 3);
    set_store('h3104, 0); step();
    do_chk(41, 1'b1, 1'b0, 1'b0, "R7 single record, killed via new range");

    // R10 same-cycle ordering
    do_alloc(51, 'h4000, 3);
    set_store('h4000, 2); set_alloc(50, 'h4000, 3, 1'b0); step();
    do_chk(51, 1'b0, 1'b0, 1'b0, "R10 existing record killed by store");
    do_chk(50, 1'b0, 1'b0, 1'b1, "R10 same-cycle allocation survives store");
    inv_all = 1'b1; set_alloc(52, 'h4100, 0, 1'b0); step();
    do_chk(52, 1'b1, 1'b0, 1'b1, "R10 allocation survives flush");
    do_chk(50, 1'b1, 1'b0, 1'b0, "R9 flush removed reg50");
    set_chk(53, 1'b1, 1'b1); set_alloc(53, 'h4200, 1, 1'b0); step();
    expect_chk(1'b0, 1'b1, "R11 clear check before same-cycle allocation");
    do_chk(53, 1'b1, 1'b0, 1'b1, "R10 allocation survives clear check");

    // R11 check observes pre-cycle state
    set_chk(60, 1'b0, 1'b0); set_alloc(60, 'h5000, 3, 1'b0); step();
    expect_chk(1'b0, 1'b0, "R11 same-cycle allocate not seen");
    do_chk(60, 1'b0, 1'b0, 1'b1, "R11 seen next cycle");
    set_chk(60, 1'b0, 1'b0); set_store('h5007, 0); step();
    expect_chk(1'b1, 1'b0, "R11 same-cycle store not seen");
    do_chk(60, 1'b0, 1'b0, 1'b0, "R2 store removed record");
    step();
    n_cmp++;
    if (chk_done !== 1'b0) begin
      n_bad++;
      $display("FAIL R4 idle: chk_done got %b expected 0", chk_done);
    end

    // R2 / R3 sweep: every size pair, store offsets -10..+10
    do_flush();
    for (int sa = 0; sa < 4; sa++)
      for (int sb = 0; sb < 4; sb++)
        for (int d = -10; d <= 10; d++) begin
          bit ov;
          ov = bytes_touch('h6000, sa, 'h6000 + d, sb);
          do_alloc(5, 'h6000, sa);
          set_store('h6000 + d, sb); step();
          set_chk(5, 1'b1, 1'b0); step();
          if ({chk_done, chk_hit, chk_reload, chk_redirect} !== {1'b1, !ov, 1'b0, ov}) begin
            n_bad++;
            $display("FAIL R2/R3 sa=%0d sb=%0d d=%0d: hit got %b expected %b",
                     sa, sb, d, chk_hit, !ov);
          end
          n_cmp++;
        end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule